// File: doc/BRIEF.md
# Bandwidth Allocation Director

This block is the central decision maker of a dynamic traffic regulation scheme. It polls a set of M traffic predictors one after another over a shared ID bus and collects a burst figure (sigma) and an average-rate figure (rho) from each. It then splits a link bandwidth budget among the masters and sends one regulation policy per master to the regulators over a second ID bus, one ID per cycle.

Each master's policy rate always equals the rho it reported. Burst allowance comes from the bandwidth left over once all rates are served. That leftover, scaled by the decision window length, is shared in proportion to each master's sigma and clamped to the range from 1 up to that master's own sigma. If no bandwidth is left, or if every sigma is zero, every master gets a burst allowance of 1. The proportional share uses a multi-cycle restoring divider, one master at a time. Broadcasting starts only when all shares are known. Polling resumes once the broadcast ends.

Top module: `bw_director`

## Requirements
- R1: While rst_n is low, poll_id is 0, fwd_valid is 0, pol_new is 0, and pol_sigma and pol_rate are 0.
- R2: While polling, poll_id holds its value until rpt_ready is sampled high. One cycle after that sample, fwd_valid is high for exactly one cycle and carries the sampled rpt_sigma and rpt_rho, and poll_id has advanced by one. Polling begins at ID 0 after reset.
- R3: After the report for ID M-1 is taken, poll_id returns to 0 and rpt_ready is ignored (fwd_valid stays low) until the broadcast has finished. The earliest rpt_ready accepted again is the one sampled on the second rising edge after pol_new falls.
- R4: With S_rho and S_sigma the sums of the M reported values, WIN the window length and budget the bandwidth input: if S_rho < budget and S_sigma > 0, master m gets sigma_R = floor((budget − S_rho)·WIN·sigma_m / S_sigma), raised to 1 if below 1 and lowered to sigma_m if above sigma_m.
- R5: If S_rho ≥ budget, every master gets sigma_R = 1.
- R6: If S_sigma = 0, every master gets sigma_R = 1.
- R7: The policy rate sent for master m equals the rho reported by master m in that round.
- R8: A broadcast holds pol_new high for exactly M consecutive cycles, with pol_id equal to 0, 1, …, M−1 in order. The policy for master pol_id is on pol_sigma and pol_rate in the same cycle. While pol_new is low, pol_sigma and pol_rate are 0.
- R9: pol_new rises 2 cycles after the fwd_valid of the last report when R5 or R6 applies. Under R4 it rises 2 + M·(N+2) cycles after that fwd_valid, with N = RATE_W + ceil(log2(M+1)) + ceil(log2(WIN+1)) + SIG_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| budget | input | RATE_W+ceil(log2(M+1)) | Link bandwidth budget per cycle, in the unit of rho |
| rpt_ready | input | 1 | Addressed predictor has a report on the bus |
| rpt_sigma | input | SIG_W | Reported burst figure |
| rpt_rho | input | RATE_W | Reported average rate |
| poll_id | output | ceil(log2(M)) | Predictor being polled |
| fwd_valid | output | 1 | One-cycle pulse when a report has been taken |
| fwd_sigma | output | SIG_W | Burst figure of the report taken |
| fwd_rho | output | RATE_W | Rate of the report taken |
| pol_new | output | 1 | Policy broadcast in progress |
| pol_id | output | ceil(log2(M)) | Regulator addressed by the broadcast |
| pol_sigma | output | SIG_W | Burst allowance for pol_id |
| pol_rate | output | RATE_W | Rate allowance for pol_id |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a predictor raising ready while the director is still broadcasting. The bench drives rpt_ready at random in every cycle, busy phases included, so the report path and the broadcast path overlap. The reference model then requires fwd_valid low and poll_id fixed until the restart edge. The second pair is the last report and the start of the arithmetic: back-to-back ready in the last poll slots is judged by comparing the exact cycle pol_new rises against the modelled latency of the fill case and the divide case.

// File: rtl/bw_director_pkg.sv
package bw_director_pkg;
  typedef enum logic [1:0] {
    AL_IDLE = 2'd0,
    AL_KICK = 2'd1,
    AL_WAIT = 2'd2
  } alloc_state_e;
endpackage

// File: rtl/bw_dir_poll.sv
module bw_dir_poll #(
  parameter int M      = 4,
  parameter int SIG_W  = 8,
  parameter int RATE_W = 8,
  parameter int ID_W   = 2,
  parameter int SSUM_W = 11,
  parameter int RSUM_W = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart_i,
  input  logic                  rpt_ready_i,
  input  logic [SIG_W-1:0]      rpt_sigma_i,
  input  logic [RATE_W-1:0]     rpt_rho_i,
  output logic [ID_W-1:0]       poll_id_o,
  output logic                  fwd_valid_o,
  output logic [SIG_W-1:0]      fwd_sigma_o,
  output logic [RATE_W-1:0]     fwd_rho_o,
  output logic                  done_o,
  output logic [M*SIG_W-1:0]    sig_flat_o,
  output logic [M*RATE_W-1:0]   rho_flat_o,
  output logic [SSUM_W-1:0]     ssum_o,
  output logic [RSUM_W-1:0]     rsum_o
);
  logic              active_q, active_d;
  logic [ID_W-1:0]   idx_q, idx_d;
  logic [SSUM_W-1:0] ssum_q, ssum_d;
  logic [RSUM_W-1:0] rsum_q, rsum_d;
  logic              fwdv_q, done_q, done_d;
  logic [SIG_W-1:0]  fwds_q;
  logic [RATE_W-1:0] fwdr_q;
  logic              take, last;

  assign take = active_q & rpt_ready_i;
  assign last = (idx_q == ID_W'(M-1));

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    ssum_d   = ssum_q;
    rsum_d   = rsum_q;
    done_d   = 1'b0;
    if (restart_i && !active_q) begin
      active_d = 1'b1;
      ssum_d   = '0;
      rsum_d   = '0;
    end
    if (take) begin
      ssum_d = ssum_q + SSUM_W'(rpt_sigma_i);
      rsum_d = rsum_q + RSUM_W'(rpt_rho_i);
      if (last) begin
        idx_d    = '0;
        active_d = 1'b0;
        done_d   = 1'b1;
      end else begin
        idx_d = idx_q + ID_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      ssum_q   <= '0;
      rsum_q   <= '0;
      fwdv_q   <= 1'b0;
      done_q   <= 1'b0;
      fwds_q   <= '0;
      fwdr_q   <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      ssum_q   <= ssum_d;
      rsum_q   <= rsum_d;
      fwdv_q   <= take;
      done_q   <= done_d;
      if (take) begin
        fwds_q <= rpt_sigma_i;
        fwdr_q <= rpt_rho_i;
      end
    end
  end

  for (genvar m = 0; m < M; m++) begin : g_slot
    logic [SIG_W-1:0]  s_q;
    logic [RATE_W-1:0] r_q;
    logic              wr;
    assign wr = take && (idx_q == ID_W'(m));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= '0;
        r_q <= '0;
      end else if (wr) begin
        s_q <= rpt_sigma_i;
        r_q <= rpt_rho_i;
      end
    end
    assign sig_flat_o[m*SIG_W +: SIG_W]   = s_q;
    assign rho_flat_o[m*RATE_W +: RATE_W] = r_q;
  end

  assign poll_id_o   = idx_q;
  assign fwd_valid_o = fwdv_q;
  assign fwd_sigma_o = fwds_q;
  assign fwd_rho_o   = fwdr_q;
  assign done_o      = done_q;
  assign ssum_o      = ssum_q;
  assign rsum_o      = rsum_q;
endmodule

// File: rtl/bw_dir_divider.sv
module bw_dir_divider #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 11,
  localparam int CNT_W = $clog2(NUM_W+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] dividend_i,
  input  logic [DEN_W-1:0] divisor_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  logic             busy_q, busy_d, done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NUM_W-1:0] dvd_q, dvd_d;
  logic [DEN_W:0]   rem_q, rem_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [DEN_W:0]   shifted;
  logic [DEN_W+1:0] trial;
  logic             fits;

  assign shifted = {rem_q[DEN_W-1:0], dvd_q[NUM_W-1]};
  assign trial   = {1'b0, shifted} - {2'b00, den_q};
  assign fits    = ~trial[DEN_W+1];

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    dvd_d  = dvd_q;
    rem_d  = rem_q;
    den_d  = den_q;
    done_d = 1'b0;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      dvd_d  = dividend_i;
      rem_d  = '0;
      den_d  = divisor_i;
    end else if (busy_q) begin
      rem_d = fits ? trial[DEN_W:0] : shifted;
      dvd_d = {dvd_q[NUM_W-2:0], fits};
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(NUM_W-1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      dvd_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      dvd_q  <= dvd_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign quot_o = dvd_q;
endmodule

// File: rtl/bw_dir_alloc.sv
module bw_dir_alloc
  import bw_director_pkg::*;
#(
  parameter int M      = 4,
  parameter int SIG_W  = 8,
  parameter int ID_W   = 2,
  parameter int RSUM_W = 11,
  parameter int SSUM_W = 11,
  parameter int WIN    = 16,
  localparam int PW_W  = $clog2(WIN+1),
  localparam int REM_W = RSUM_W + PW_W,
  localparam int NUM_W = REM_W + SIG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [M*SIG_W-1:0] sig_flat_i,
  input  logic [SSUM_W-1:0]  ssum_i,
  input  logic [RSUM_W-1:0]  rsum_i,
  input  logic [RSUM_W-1:0]  budget_i,
  output logic               done_o,
  output logic [M*SIG_W-1:0] res_flat_o
);
  alloc_state_e      st_q, st_d;
  logic [ID_W-1:0]   idx_q, idx_d;
  logic [REM_W-1:0]  left_q, left_d;
  logic              done_q, done_d, fill, wr;
  logic [SIG_W-1:0]  sig_arr [M];
  logic [SIG_W-1:0]  sig_cur, share;
  logic [NUM_W-1:0]  quot;
  logic              div_done;

  for (genvar m = 0; m < M; m++) begin : g_unpack
    assign sig_arr[m] = sig_flat_i[m*SIG_W +: SIG_W];
  end
  assign sig_cur = sig_arr[idx_q];

  bw_dir_divider #(.NUM_W(NUM_W), .DEN_W(SSUM_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (st_q == AL_KICK),
    .dividend_i (NUM_W'(left_q) * NUM_W'(sig_cur)),
    .divisor_i  (ssum_i),
    .done_o     (div_done),
    .quot_o     (quot)
  );

  always_comb begin
    if (quot == '0)                     share = SIG_W'(1);
    else if (quot > NUM_W'(sig_cur))    share = sig_cur;
    else                                share = quot[SIG_W-1:0];
  end

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    left_d = left_q;
    done_d = 1'b0;
    fill   = 1'b0;
    wr     = 1'b0;
    unique case (st_q)
      AL_IDLE: if (start_i) begin
        if ((rsum_i < budget_i) && (ssum_i != '0)) begin
          left_d = REM_W'(budget_i - rsum_i) * REM_W'(WIN);
          idx_d  = '0;
          st_d   = AL_KICK;
        end else begin
          fill   = 1'b1;
          done_d = 1'b1;
        end
      end
      AL_KICK: st_d = AL_WAIT;
      AL_WAIT: if (div_done) begin
        wr = 1'b1;
        if (idx_q == ID_W'(M-1)) begin
          st_d   = AL_IDLE;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + ID_W'(1);
          st_d  = AL_KICK;
        end
      end
      default: st_d = AL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= AL_IDLE;
      idx_q  <= '0;
      left_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      left_q <= left_d;
      done_q <= done_d;
    end
  end

  for (genvar m = 0; m < M; m++) begin : g_res
    logic [SIG_W-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              r_q <= '0;
      else if (fill)                           r_q <= SIG_W'(1);
      else if (wr && (idx_q == ID_W'(m)))      r_q <= share;
    end
    assign res_flat_o[m*SIG_W +: SIG_W] = r_q;
  end

  assign done_o = done_q;
endmodule

// File: rtl/bw_dir_bcast.sv
module bw_dir_bcast #(
  parameter int M      = 4,
  parameter int SIG_W  = 8,
  parameter int RATE_W = 8,
  parameter int ID_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [M*SIG_W-1:0]  res_flat_i,
  input  logic [M*RATE_W-1:0] rho_flat_i,
  output logic                pol_new_o,
  output logic [ID_W-1:0]     pol_id_o,
  output logic [SIG_W-1:0]    pol_sigma_o,
  output logic [RATE_W-1:0]   pol_rate_o,
  output logic                done_o
);
  logic              on_q, on_d, done_q, done_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic [SIG_W-1:0]  res_arr [M];
  logic [RATE_W-1:0] rho_arr [M];

  for (genvar m = 0; m < M; m++) begin : g_unpack
    assign res_arr[m] = res_flat_i[m*SIG_W +: SIG_W];
    assign rho_arr[m] = rho_flat_i[m*RATE_W +: RATE_W];
  end

  always_comb begin
    on_d   = on_q;
    id_d   = id_q;
    done_d = 1'b0;
    if (start_i && !on_q) begin
      on_d = 1'b1;
      id_d = '0;
    end else if (on_q) begin
      if (id_q == ID_W'(M-1)) begin
        on_d   = 1'b0;
        id_d   = '0;
        done_d = 1'b1;
      end else begin
        id_d = id_q + ID_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      id_q   <= '0;
      done_q <= 1'b0;
    end else begin
      on_q   <= on_d;
      id_q   <= id_d;
      done_q <= done_d;
    end
  end

  assign pol_new_o   = on_q;
  assign pol_id_o    = id_q;
  assign pol_sigma_o = on_q ? res_arr[id_q] : '0;
  assign pol_rate_o  = on_q ? rho_arr[id_q] : '0;
  assign done_o      = done_q;
endmodule

// File: rtl/bw_director.sv
module bw_director #(
  parameter int M      = 4,
  parameter int SIG_W  = 8,
  parameter int RATE_W = 8,
  parameter int WIN    = 16,
  localparam int ID_W   = (M > 1) ? $clog2(M) : 1,
  localparam int RSUM_W = RATE_W + $clog2(M+1),
  localparam int SSUM_W = SIG_W + $clog2(M+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RSUM_W-1:0] budget,
  input  logic              rpt_ready,
  input  logic [SIG_W-1:0]  rpt_sigma,
  input  logic [RATE_W-1:0] rpt_rho,
  output logic [ID_W-1:0]   poll_id,
  output logic              fwd_valid,
  output logic [SIG_W-1:0]  fwd_sigma,
  output logic [RATE_W-1:0] fwd_rho,
  output logic              pol_new,
  output logic [ID_W-1:0]   pol_id,
  output logic [SIG_W-1:0]  pol_sigma,
  output logic [RATE_W-1:0] pol_rate
);
  logic                poll_done, alloc_done, bc_done;
  logic [M*SIG_W-1:0]  sig_flat, res_flat;
  logic [M*RATE_W-1:0] rho_flat;
  logic [SSUM_W-1:0]   ssum;
  logic [RSUM_W-1:0]   rsum;

  bw_dir_poll #(
    .M(M), .SIG_W(SIG_W), .RATE_W(RATE_W), .ID_W(ID_W),
    .SSUM_W(SSUM_W), .RSUM_W(RSUM_W)
  ) u_poll (
    .clk(clk), .rst_n(rst_n), .restart_i(bc_done),
    .rpt_ready_i(rpt_ready), .rpt_sigma_i(rpt_sigma), .rpt_rho_i(rpt_rho),
    .poll_id_o(poll_id), .fwd_valid_o(fwd_valid), .fwd_sigma_o(fwd_sigma),
    .fwd_rho_o(fwd_rho), .done_o(poll_done), .sig_flat_o(sig_flat),
    .rho_flat_o(rho_flat), .ssum_o(ssum), .rsum_o(rsum)
  );

  bw_dir_alloc #(
    .M(M), .SIG_W(SIG_W), .ID_W(ID_W), .RSUM_W(RSUM_W),
    .SSUM_W(SSUM_W), .WIN(WIN)
  ) u_alloc (
    .clk(clk), .rst_n(rst_n), .start_i(poll_done), .sig_flat_i(sig_flat),
    .ssum_i(ssum), .rsum_i(rsum), .budget_i(budget),
    .done_o(alloc_done), .res_flat_o(res_flat)
  );

  bw_dir_bcast #(
    .M(M), .SIG_W(SIG_W), .RATE_W(RATE_W), .ID_W(ID_W)
  ) u_bcast (
    .clk(clk), .rst_n(rst_n), .start_i(alloc_done), .res_flat_i(res_flat),
    .rho_flat_i(rho_flat), .pol_new_o(pol_new), .pol_id_o(pol_id),
    .pol_sigma_o(pol_sigma), .pol_rate_o(pol_rate), .done_o(bc_done)
  );
endmodule

// File: rtl/bw_director_chk.sv
module bw_director_chk #(
  parameter int M      = 4,
  parameter int SIG_W  = 8,
  parameter int RATE_W = 8,
  parameter int ID_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rpt_ready,
  input logic [SIG_W-1:0]  rpt_sigma,
  input logic [RATE_W-1:0] rpt_rho,
  input logic [ID_W-1:0]   poll_id,
  input logic              fwd_valid,
  input logic [SIG_W-1:0]  fwd_sigma,
  input logic [RATE_W-1:0] fwd_rho,
  input logic              pol_new,
  input logic [ID_W-1:0]   pol_id,
  input logic [SIG_W-1:0]  pol_sigma
);
  assert_fwd_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_sigma == $past(rpt_sigma)) && (fwd_rho == $past(rpt_rho)));

  assert_fwd_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> poll_id == (($past(poll_id) == ID_W'(M-1)) ? '0 : ID_W'($past(poll_id) + 1'b1)));

  assert_id_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_valid |-> $stable(poll_id));

  assert_bc_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pol_new) |-> pol_id == '0);

  assert_bc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_new && $past(pol_new)) |-> pol_id == ID_W'($past(pol_id) + 1'b1));

  assert_bc_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pol_new) |-> $past(pol_id) == ID_W'(M-1));

  assert_sigma_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pol_new |-> pol_sigma != '0);

  assert_quiet_while_bcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pol_new |-> !fwd_valid);
endmodule

bind bw_director bw_director_chk #(
  .M(M), .SIG_W(SIG_W), .RATE_W(RATE_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rpt_ready(rpt_ready), .rpt_sigma(rpt_sigma),
  .rpt_rho(rpt_rho), .poll_id(poll_id), .fwd_valid(fwd_valid),
  .fwd_sigma(fwd_sigma), .fwd_rho(fwd_rho), .pol_new(pol_new),
  .pol_id(pol_id), .pol_sigma(pol_sigma)
);

// File: tb/bw_director_tb.sv
module bw_director_tb;
  localparam int M      = 4;
  localparam int SIG_W  = 8;
  localparam int RATE_W = 8;
  localparam int WIN    = 16;
  localparam int ID_W   = 2;
  localparam int RSUM_W = RATE_W + $clog2(M+1);
  localparam int NUM_W  = RSUM_W + $clog2(WIN+1) + SIG_W;
  localparam int DDIV   = M * (NUM_W + 2);
  localparam int NR     = 10;

  logic              clk, rst_n, rpt_ready;
  logic [RSUM_W-1:0] budget;
  logic [SIG_W-1:0]  rpt_sigma, fwd_sigma, pol_sigma;
  logic [RATE_W-1:0] rpt_rho, fwd_rho, pol_rate;
  logic [ID_W-1:0]   poll_id, pol_id;
  logic              fwd_valid, pol_new;

  bw_director #(.M(M), .SIG_W(SIG_W), .RATE_W(RATE_W), .WIN(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .budget(budget), .rpt_ready(rpt_ready),
    .rpt_sigma(rpt_sigma), .rpt_rho(rpt_rho), .poll_id(poll_id),
    .fwd_valid(fwd_valid), .fwd_sigma(fwd_sigma), .fwd_rho(fwd_rho),
    .pol_new(pol_new), .pol_id(pol_id), .pol_sigma(pol_sigma), .pol_rate(pol_rate)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  int vs [M], vr [M];
  int bw_val = 0, prob = 100;
  bit finished = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // reference model state
  bit     m_act, e_fv, e_new, rs;
  int     m_idx, e_fs, e_fr, e_pid, bc_cnt, rounds_done;
  int     ms [M], mr [M], e_ps [M], e_pr [M];
  string  e_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 1; m_idx = 0; e_fv = 0; e_new = 0; e_pid = 0;
      bc_cnt = 0; rs = 0; rounds_done = 0; e_tag = "R4";
    end else begin
      bit was_act;
      was_act = m_act;
      if (rs) begin m_act = 1; rs = 0; end
      if (e_new) begin
        if (e_pid == M-1) begin e_new = 0; e_pid = 0; rs = 1; rounds_done++; end
        else e_pid++;
      end else if (bc_cnt > 0) begin
        bc_cnt--;
        if (bc_cnt == 0) begin e_new = 1; e_pid = 0; end
      end
      e_fv = 0;
      if (was_act && rpt_ready) begin
        e_fv = 1; e_fs = rpt_sigma; e_fr = rpt_rho;
        ms[m_idx] = rpt_sigma; mr[m_idx] = rpt_rho;
        if (m_idx == M-1) begin
          longint ss, sr, left, q;
          m_idx = 0; m_act = 0; ss = 0; sr = 0;
          for (int i = 0; i < M; i++) begin ss += ms[i]; sr += mr[i]; end
          if (sr < bw_val && ss != 0) begin
            left = (bw_val - sr) * WIN;
            for (int i = 0; i < M; i++) begin
              q = left * ms[i] / ss;
              if (q < 1) q = 1; else if (q > ms[i]) q = ms[i];
              e_ps[i] = int'(q);
            end
            bc_cnt = 2 + DDIV; e_tag = "R4";
          end else begin
            for (int i = 0; i < M; i++) e_ps[i] = 1;
            bc_cnt = 2; e_tag = (sr >= bw_val) ? "R5" : "R6";
          end
          for (int i = 0; i < M; i++) e_pr[i] = mr[i];
        end else m_idx++;
      end
    end
  end

  // predictor emulation and comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_act ? "R2 poll_id" : "R3 poll_id", poll_id, m_idx);
      chk(m_act ? "R2 fwd_valid" : "R3 fwd_valid", fwd_valid, e_fv);
      if (e_fv) begin
        chk("R2 fwd_sigma", fwd_sigma, e_fs);
        chk("R2 fwd_rho", fwd_rho, e_fr);
      end
      chk("R9 pol_new", pol_new, e_new);
      if (e_new && pol_new) begin
        chk("R8 pol_id", pol_id, e_pid);
        chk({e_tag, " pol_sigma"}, pol_sigma, e_ps[e_pid]);
        chk("R7 pol_rate", pol_rate, e_pr[e_pid]);
      end else if (!pol_new) begin
        chk("R8 idle sigma", pol_sigma, 0);
        chk("R8 idle rate", pol_rate, 0);
      end
      rpt_ready <= ($urandom_range(99) < prob);
      rpt_sigma <= SIG_W'(vs[poll_id]);
      rpt_rho   <= RATE_W'(vr[poll_id]);
    end
  end

  task automatic load_round(input int r);
    int s0 [M], r0 [M];
    case (r)
      0: begin bw_val = 52;  r0 = '{10,20,5,15}; s0 = '{100,50,10,0};     prob = 100; end
      1: begin bw_val = 100; r0 = '{10,20,5,15}; s0 = '{3,40,0,200};      prob = 60;  end
      2: begin bw_val = 50;  r0 = '{10,20,5,15}; s0 = '{9,9,9,9};         prob = 40;  end
      3: begin bw_val = 51;  r0 = '{10,20,5,15}; s0 = '{0,0,0,0};         prob = 70;  end
      4: begin bw_val = 51;  r0 = '{10,20,5,15}; s0 = '{255,255,255,255}; prob = 100; end
      default: begin
        bw_val = $urandom_range(2047);
        for (int i = 0; i < M; i++) begin
          r0[i] = $urandom_range(255); s0[i] = $urandom_range(255);
        end
        prob = 20 + $urandom_range(80);
      end
    endcase
    for (int i = 0; i < M; i++) begin vs[i] = s0[i]; vr[i] = r0[i]; end
    budget = RSUM_W'(bw_val);
  endtask

  initial begin
    rst_n = 1'b0; rpt_ready = 1'b0; rpt_sigma = '0; rpt_rho = '0;
    load_round(0);
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 poll_id", poll_id, 0);
    chk("R1 fwd_valid", fwd_valid, 0);
    chk("R1 pol_new", pol_new, 0);
    chk("R1 pol_sigma", pol_sigma, 0);
    chk("R1 pol_rate", pol_rate, 0);
    rst_n = 1'b1;
    for (int r = 0; r < NR; r++) begin
      if (r > 0) load_round(r);
      wait (rounds_done == r + 1);
    end
    repeat (5) @(negedge clk);
    wrap_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=%0d rounds", NR);
    wrap_up();
  end
endmodule